// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block sits between an instruction fetch stage and the execution units of a multithreaded streaming core. It keeps one buffered instruction per resident warp (24 warps by default), asks the fetch stage for the next instruction of the lowest warp that has work and an empty buffer entry, and each cycle sends at most one ready instruction to execution. Warps therefore issue out of order with respect to each other but strictly in order within a warp, because a warp holds only one buffered instruction at a time.

Readiness comes from a per-warp register scoreboard. When an instruction issues, its destination register is marked pending in its warp's scoreboard. A writeback port names a warp and a register and clears that mark. A buffered instruction may issue only when neither of its two source registers nor its destination register is pending, so a warp waiting on a long-latency result does not hold up any other warp. When several warps are ready, a mode input selects either a round-robin order that rotates from the warp issued last, or an oldest-first order in which the entry filled earliest wins.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset all buffer entries are empty, no register is pending, and `iss_valid` is low.
- R2: `fetch_req_valid` is high exactly when some warp has its `warp_active` bit set and an empty buffer entry; `fetch_req_warp` is then the lowest such warp index. Both follow the current state without a register stage.
- R3: A fill (`fill_valid` high) is accepted only when `fill_warp` is below NUM_WARPS and that warp's entry is empty at the start of the cycle; a fill to an occupied entry or to an out-of-range warp changes nothing.
- R4: A buffered instruction is eligible only when its source A, source B and destination registers are all clear in its own warp's scoreboard.
- R5: At most one instruction issues per cycle. The choice made in cycle t appears on `iss_valid`, `iss_warp`, `iss_dst`, `iss_src_a`, `iss_src_b` after the clock edge ending cycle t, and the entry is empty from then on.
- R6: Issue marks the destination register of the issued warp as pending; a writeback (`wb_valid`, `wb_warp`, `wb_reg`) clears it, and an instruction waiting on that register may be chosen in the cycle after the writeback.
- R7: When a writeback and an issue address the same warp and register in one cycle, the clear is applied first and the set second, so the register ends pending.
- R8: With `mode_age` = 0 (round-robin), the search for a ready warp starts at the warp following the last issued one and wraps past NUM_WARPS-1 to 0; after reset the search starts at warp 0.
- R9: With `mode_age` = 1 (oldest first), the ready entry that was filled earliest is chosen.
- R10: A warp stalled on its scoreboard never prevents a ready instruction of another warp from issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_age | input | 1 | Priority: 0 round-robin, 1 oldest first |
| warp_active | input | NUM_WARPS | Warps that have further instructions to fetch |
| fetch_req_valid | output | 1 | A fetch target exists |
| fetch_req_warp | output | $clog2(NUM_WARPS) | Warp to fetch for |
| fill_valid | input | 1 | Fetched instruction present |
| fill_warp | input | $clog2(NUM_WARPS) | Warp of the fetched instruction |
| fill_dst | input | $clog2(NUM_REGS) | Destination register |
| fill_src_a | input | $clog2(NUM_REGS) | First source register |
| fill_src_b | input | $clog2(NUM_REGS) | Second source register |
| wb_valid | input | 1 | Writeback present |
| wb_warp | input | $clog2(NUM_WARPS) | Warp of the writeback |
| wb_reg | input | $clog2(NUM_REGS) | Register written back |
| iss_valid | output | 1 | An instruction issued |
| iss_warp | output | $clog2(NUM_WARPS) | Warp of the issued instruction |
| iss_dst | output | $clog2(NUM_REGS) | Issued destination register |
| iss_src_a | output | $clog2(NUM_REGS) | Issued first source register |
| iss_src_b | output | $clog2(NUM_REGS) | Issued second source register |

## Verification
On every cycle the assertions check that an issued destination is pending right after issue, that a writeback clears a bit unless a same-cycle issue sets it again, that a chosen entry had clear operands and is emptied, that an accepted fill lands, and that the oldest-first selector yields exactly one winner whenever something is ready. Which warp should win under each priority mode, the wrap of the round-robin search, the ordering of clear before set, and the silence of rejected fills can only be shown by the bench's reference model, which tracks ages, pointers and scoreboards on its own and is compared on every clock across directed and random traffic in both modes.

// File: rtl/ws_pkg.sv
package ws_pkg;
   typedef enum logic {
      PICK_ROUND_ROBIN = 1'b0,
      PICK_OLDEST      = 1'b1
   } pick_mode_e;
endpackage

// File: rtl/ws_scoreboard.sv
module ws_scoreboard #(
   parameter int unsigned NUM_WARPS = 24,
   parameter int unsigned NUM_REGS  = 16,
   localparam int unsigned WW = $clog2(NUM_WARPS),
   localparam int unsigned RW = $clog2(NUM_REGS)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                set_en,
   input  logic [WW-1:0]                       set_warp,
   input  logic [RW-1:0]                       set_reg,
   input  logic                                clr_en,
   input  logic [WW-1:0]                       clr_warp,
   input  logic [RW-1:0]                       clr_reg,
   input  logic [NUM_WARPS-1:0]                slot_vld,
   input  logic [NUM_WARPS-1:0][RW-1:0]        slot_dst,
   input  logic [NUM_WARPS-1:0][RW-1:0]        slot_src_a,
   input  logic [NUM_WARPS-1:0][RW-1:0]        slot_src_b,
   output logic [NUM_WARPS-1:0]                elig,
   output logic [NUM_WARPS-1:0][NUM_REGS-1:0]  pend
);
   logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend_nxt;

   // clear first, then set: a same-cycle collision leaves the bit pending
   always_comb begin
      pend_nxt = pend;
      if (clr_en) pend_nxt[clr_warp][clr_reg] = 1'b0;
      if (set_en) pend_nxt[set_warp][set_reg] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= pend_nxt;
   end

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
      assign elig[w] = slot_vld[w]
                     & ~pend[w][slot_src_a[w]]
                     & ~pend[w][slot_src_b[w]]
                     & ~pend[w][slot_dst[w]];
   end

   // R6: a writeback clears its bit unless the same bit is set by issue
   a_r6_wb_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(set_en && set_warp == clr_warp && set_reg == clr_reg))
      |=> !pend[$past(clr_warp)][$past(clr_reg)]);
   // R7: a collision ends with the bit pending
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && set_en && set_warp == clr_warp && set_reg == clr_reg)
      |=> pend[$past(set_warp)][$past(set_reg)]);
endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
   parameter int unsigned NUM_WARPS = 24,
   localparam int unsigned WW = $clog2(NUM_WARPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] elig,
   input  logic                 adv_en,
   input  logic [WW-1:0]        adv_warp,
   output logic                 pick_valid,
   output logic [WW-1:0]        pick_idx
);
   logic [WW-1:0] last_q;
   int            cand;

   always_ff @(posedge clk) begin
      if (!rst_n)      last_q <= WW'(NUM_WARPS - 1);
      else if (adv_en) last_q <= adv_warp;
   end

   always_comb begin
      pick_valid = 1'b0;
      pick_idx   = '0;
      cand       = 0;
      for (int k = 1; k <= int'(NUM_WARPS); k++) begin
         cand = int'(last_q) + k;
         if (cand >= int'(NUM_WARPS)) cand = cand - int'(NUM_WARPS);
         if (!pick_valid && elig[cand]) begin
            pick_valid = 1'b1;
            pick_idx   = WW'(cand);
         end
      end
   end

   // R8: the round-robin choice is always a ready warp
   a_r8_pick_ready: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> elig[pick_idx]);
endmodule

// File: rtl/ws_age_order.sv
module ws_age_order #(
   parameter int unsigned NUM_WARPS = 24,
   localparam int unsigned WW = $clog2(NUM_WARPS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fill_en,
   input  logic [WW-1:0]        fill_idx,
   input  logic [NUM_WARPS-1:0] elig,
   output logic                 pick_valid,
   output logic [WW-1:0]        pick_idx
);
   // older[i][j] set: entry i was filled before entry j
   logic [NUM_WARPS-1:0] older [NUM_WARPS];
   logic [NUM_WARPS-1:0] win;

   for (genvar i = 0; i < NUM_WARPS; i++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) older[i] <= '0;
         else if (fill_en) begin
            if (fill_idx == WW'(i)) older[i] <= '0;
            else                    older[i][fill_idx] <= 1'b1;
         end
      end
   end

   always_comb begin
      for (int i = 0; i < int'(NUM_WARPS); i++) begin
         win[i] = elig[i];
         for (int j = 0; j < int'(NUM_WARPS); j++)
            if (j != i && elig[j] && older[j][i]) win[i] = 1'b0;
      end
      pick_valid = |win;
      pick_idx   = '0;
      for (int i = 0; i < int'(NUM_WARPS); i++)
         if (win[i]) pick_idx = WW'(i);
   end

   // R9: exactly one oldest winner whenever anything is ready
   a_r9_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win));
   a_r9_winner_exists: assert property (@(posedge clk) disable iff (!rst_n)
      (|elig) |-> (|win));
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
   import ws_pkg::*;
#(
   parameter int unsigned NUM_WARPS   = 24,
   parameter int unsigned NUM_REGS    = 16,
   parameter bit          AGE_PICK_EN = 1'b1,
   localparam int unsigned WW = $clog2(NUM_WARPS),
   localparam int unsigned RW = $clog2(NUM_REGS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_age,
   input  logic [NUM_WARPS-1:0] warp_active,
   output logic                 fetch_req_valid,
   output logic [WW-1:0]        fetch_req_warp,
   input  logic                 fill_valid,
   input  logic [WW-1:0]        fill_warp,
   input  logic [RW-1:0]        fill_dst,
   input  logic [RW-1:0]        fill_src_a,
   input  logic [RW-1:0]        fill_src_b,
   input  logic                 wb_valid,
   input  logic [WW-1:0]        wb_warp,
   input  logic [RW-1:0]        wb_reg,
   output logic                 iss_valid,
   output logic [WW-1:0]        iss_warp,
   output logic [RW-1:0]        iss_dst,
   output logic [RW-1:0]        iss_src_a,
   output logic [RW-1:0]        iss_src_b
);
   localparam logic [WW:0] WARP_LIM = (WW+1)'(NUM_WARPS);

   if (NUM_WARPS < 2 || NUM_REGS < 2 || NUM_REGS != (1 << RW)) begin : g_bad_cfg
      $error("warp_issue_sched: NUM_WARPS >= 2 and power-of-two NUM_REGS >= 2 required");
   end

   logic [NUM_WARPS-1:0]                slot_vld;
   logic [NUM_WARPS-1:0][RW-1:0]        slot_dst, slot_src_a, slot_src_b;
   logic [NUM_WARPS-1:0]                elig;
   logic [NUM_WARPS-1:0][NUM_REGS-1:0]  pend;
   logic                                fill_acc, wb_ok;
   logic                                rr_valid, pick_valid;
   logic [WW-1:0]                       rr_idx, pick_idx;

   assign fill_acc = fill_valid && ({1'b0, fill_warp} < WARP_LIM) && !slot_vld[fill_warp];
   assign wb_ok    = wb_valid && ({1'b0, wb_warp} < WARP_LIM);

   // lowest active warp with an empty entry
   always_comb begin
      fetch_req_valid = 1'b0;
      fetch_req_warp  = '0;
      for (int w = int'(NUM_WARPS) - 1; w >= 0; w--) begin
         if (warp_active[w] && !slot_vld[w]) begin
            fetch_req_valid = 1'b1;
            fetch_req_warp  = WW'(w);
         end
      end
   end

   ws_scoreboard #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_sb (
      .clk(clk), .rst_n(rst_n),
      .set_en(pick_valid), .set_warp(pick_idx), .set_reg(slot_dst[pick_idx]),
      .clr_en(wb_ok), .clr_warp(wb_warp), .clr_reg(wb_reg),
      .slot_vld(slot_vld), .slot_dst(slot_dst),
      .slot_src_a(slot_src_a), .slot_src_b(slot_src_b),
      .elig(elig), .pend(pend)
   );

   ws_rr_pick #(.NUM_WARPS(NUM_WARPS)) u_rr (
      .clk(clk), .rst_n(rst_n), .elig(elig),
      .adv_en(pick_valid), .adv_warp(pick_idx),
      .pick_valid(rr_valid), .pick_idx(rr_idx)
   );

   if (AGE_PICK_EN) begin : g_age
      logic          age_valid;
      logic [WW-1:0] age_idx;
      ws_age_order #(.NUM_WARPS(NUM_WARPS)) u_age (
         .clk(clk), .rst_n(rst_n), .fill_en(fill_acc), .fill_idx(fill_warp),
         .elig(elig), .pick_valid(age_valid), .pick_idx(age_idx)
      );
      assign pick_valid = (mode_age == PICK_OLDEST) ? age_valid : rr_valid;
      assign pick_idx   = (mode_age == PICK_OLDEST) ? age_idx   : rr_idx;
   end else begin : g_rr_only
      assign pick_valid = rr_valid;
      assign pick_idx   = rr_idx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_vld  <= '0;
         iss_valid <= 1'b0;
         iss_warp  <= '0;
         iss_dst   <= '0;
         iss_src_a <= '0;
         iss_src_b <= '0;
      end else begin
         iss_valid <= pick_valid;
         if (pick_valid) begin
            slot_vld[pick_idx] <= 1'b0;
            iss_warp  <= pick_idx;
            iss_dst   <= slot_dst[pick_idx];
            iss_src_a <= slot_src_a[pick_idx];
            iss_src_b <= slot_src_b[pick_idx];
         end
         if (fill_acc) slot_vld[fill_warp] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_acc) begin
         slot_dst[fill_warp]   <= fill_dst;
         slot_src_a[fill_warp] <= fill_src_a;
         slot_src_b[fill_warp] <= fill_src_b;
      end
   end

   // R3: an accepted fill occupies its entry on the next cycle
   a_r3_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
      fill_acc |=> slot_vld[$past(fill_warp)]);
   // R4: the chosen entry has no pending operand
   a_r4_operands_clear: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> (slot_vld[pick_idx]
                      && !pend[pick_idx][slot_src_a[pick_idx]]
                      && !pend[pick_idx][slot_src_b[pick_idx]]
                      && !pend[pick_idx][slot_dst[pick_idx]]));
   // R5: the chosen entry is emptied
   a_r5_slot_freed: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |=> !slot_vld[$past(pick_idx)]);
   // R6: right after issue the destination is pending
   a_r6_dst_pending: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> pend[iss_warp][iss_dst]);
endmodule

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 24;
   localparam int NR = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          mode_age;
   logic [NW-1:0] warp_active;
   logic          fetch_req_valid;
   logic [4:0]    fetch_req_warp;
   logic          fill_valid;
   logic [4:0]    fill_warp;
   logic [3:0]    fill_dst, fill_src_a, fill_src_b;
   logic          wb_valid;
   logic [4:0]    wb_warp;
   logic [3:0]    wb_reg;
   logic          iss_valid;
   logic [4:0]    iss_warp;
   logic [3:0]    iss_dst, iss_src_a, iss_src_b;

   int checks = 0;
   int failures = 0;

   // reference model state
   bit m_vld [NW];
   int m_dst [NW], m_sa [NW], m_sb [NW], m_ts [NW];
   bit m_pend [NW][NR];
   int m_last, ts_ctr;

   always #(CLK_PERIOD/2) clk = ~clk;

   warp_issue_sched dut_i (
      .clk(clk), .rst_n(rst_n), .mode_age(mode_age), .warp_active(warp_active),
      .fetch_req_valid(fetch_req_valid), .fetch_req_warp(fetch_req_warp),
      .fill_valid(fill_valid), .fill_warp(fill_warp), .fill_dst(fill_dst),
      .fill_src_a(fill_src_a), .fill_src_b(fill_src_b),
      .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
      .iss_valid(iss_valid), .iss_warp(iss_warp), .iss_dst(iss_dst),
      .iss_src_a(iss_src_a), .iss_src_b(iss_src_b)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int w = 0; w < NW; w++) begin
         m_vld[w] = 0;
         for (int r = 0; r < NR; r++) m_pend[w][r] = 0;
      end
      m_last = NW - 1;
      ts_ctr = 0;
   endtask

   function automatic bit m_ready(int w);
      return m_vld[w] && !m_pend[w][m_sa[w]] && !m_pend[w][m_sb[w]] && !m_pend[w][m_dst[w]];
   endfunction

   // one clock: compare fetch request, advance, compare issue, update model
   task automatic cyc();
      int ef, pick, best;
      bit fill_ok;
      #1;
      ef = -1;
      for (int w = NW - 1; w >= 0; w--) if (warp_active[w] && !m_vld[w]) ef = w;
      chk(fetch_req_valid == (ef >= 0), "R2 fetch_req_valid", fetch_req_valid, ef >= 0);
      if (ef >= 0) chk(fetch_req_warp == ef, "R2 fetch_req_warp", fetch_req_warp, ef);
      pick = -1;
      if (mode_age) begin
         best = 0;
         for (int w = 0; w < NW; w++)
            if (m_ready(w) && (pick < 0 || m_ts[w] < best)) begin pick = w; best = m_ts[w]; end
      end else begin
         for (int k = 1; k <= NW; k++)
            if (pick < 0 && m_ready((m_last + k) % NW)) pick = (m_last + k) % NW;
      end
      fill_ok = fill_valid && (int'(fill_warp) < NW) && !m_vld[fill_warp];
      @(posedge clk);
      #1;
      chk(iss_valid == (pick >= 0), "R5/R4/R10 iss_valid", iss_valid, pick >= 0);
      if (pick >= 0) begin
         chk(iss_warp == pick, "R8/R9 iss_warp", iss_warp, pick);
         chk(iss_dst == m_dst[pick] && iss_src_a == m_sa[pick] && iss_src_b == m_sb[pick],
             "R5 iss fields", {iss_dst, iss_src_a, iss_src_b},
             {m_dst[pick][3:0], m_sa[pick][3:0], m_sb[pick][3:0]});
      end
      // clear before set (R7)
      if (wb_valid && int'(wb_warp) < NW) m_pend[wb_warp][wb_reg] = 0;
      if (pick >= 0) begin
         m_pend[pick][m_dst[pick]] = 1;
         m_vld[pick] = 0;
         m_last = pick;
      end
      if (fill_ok) begin
         m_vld[fill_warp] = 1;
         m_dst[fill_warp] = fill_dst;
         m_sa[fill_warp]  = fill_src_a;
         m_sb[fill_warp]  = fill_src_b;
         m_ts[fill_warp]  = ts_ctr++;
      end
   endtask

   task automatic idle_in();
      fill_valid = 0; wb_valid = 0;
   endtask

   task automatic put(input int w, input int d, input int a, input int b);
      fill_valid = 1; fill_warp = 5'(w); fill_dst = 4'(d); fill_src_a = 4'(a); fill_src_b = 4'(b);
   endtask

   task automatic wb(input int w, input int r);
      wb_valid = 1; wb_warp = 5'(w); wb_reg = 4'(r);
   endtask

   task automatic do_reset();
      rst_n = 0; idle_in(); warp_active = '0;
      fill_warp = 0; fill_dst = 0; fill_src_a = 0; fill_src_b = 0; wb_warp = 0; wb_reg = 0;
      repeat (3) @(posedge clk);
      #1; rst_n = 1;
      model_reset();
   endtask

   // two warps become ready together; returns first and second issued warp
   task automatic race(input bit age, output int first, output int second);
      do_reset();
      mode_age = age;
      put(9, 7, 0, 0);              cyc();
      idle_in();                     cyc();
      put(9, 8, 7, 0);              cyc();
      idle_in(); put(2, 3, 0, 1); wb(9, 7); cyc();
      idle_in();                     cyc();
      first = iss_valid ? int'(iss_warp) : -1;
      cyc();
      second = iss_valid ? int'(iss_warp) : -1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int f, s;
      mode_age = 0;
      do_reset();
      // R1: reset state
      #1;
      chk(iss_valid == 0, "R1 iss_valid after reset", iss_valid, 0);
      chk(fetch_req_valid == 0, "R1/R2 no request when idle", fetch_req_valid, 0);
      warp_active = 24'h000088;
      #1;
      chk(fetch_req_valid == 1 && fetch_req_warp == 3, "R2 lowest active warp", fetch_req_warp, 3);
      warp_active = '1;
      #1;
      chk(fetch_req_warp == 0, "R1 all entries empty", fetch_req_warp, 0);

      // R8 vs R9: same traffic, two priorities
      race(0, f, s);
      chk(f == 2, "R8 round-robin after warp 9", f, 2);
      chk(s == 9, "R8 round-robin second", s, 9);
      race(1, f, s);
      chk(f == 9, "R9 oldest first", f, 9);
      chk(s == 2, "R9 younger second", s, 2);

      // R7, R6, R10, R3
      do_reset();
      mode_age = 0;
      warp_active = 24'h000001;
      put(0, 5, 1, 2);   cyc();
      idle_in(); wb(0, 5); cyc();           // issue and spurious writeback of r5 together
      idle_in(); put(0, 6, 5, 0); cyc();   // needs r5
      idle_in(); put(1, 4, 0, 0); cyc();
      chk(iss_valid == 0, "R7 r5 still pending", iss_valid, 0);
      idle_in(); put(0, 9, 0, 0); cyc();   // entry 0 occupied: ignored
      chk(iss_valid == 1 && iss_warp == 1, "R10 warp 1 issues past stalled warp 0", iss_warp, 1);
      idle_in(); put(30, 0, 0, 0); cyc(); // out of range warp
      chk(iss_valid == 0, "R3 out-of-range fill ignored", iss_valid, 0);
      chk(fetch_req_valid == 0, "R3 entry 0 still held", fetch_req_valid, 0);
      idle_in(); wb(0, 5); cyc();
      idle_in();         cyc();
      chk(iss_valid == 1 && iss_warp == 0, "R6 issue after writeback", iss_warp, 0);
      chk(iss_dst == 6, "R3 rejected fill left dst", iss_dst, 6);

      // random traffic, both priorities
      do_reset();
      for (int n = 0; n < 6000; n++) begin
         mode_age = (n >= 3000);
         warp_active = NW'($urandom);
         fill_valid = ($urandom_range(0, 9) < 7);
         fill_warp = 5'($urandom_range(0, 25));
         fill_dst = 4'($urandom_range(0, 3));
         fill_src_a = 4'($urandom_range(0, 3));
         fill_src_b = 4'($urandom_range(0, 3));
         wb_valid = ($urandom_range(0, 9) < 6);
         wb_warp = 5'($urandom_range(0, NW - 1));
         wb_reg = 4'($urandom_range(0, 3));
         cyc();
      end
      idle_in();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule